// File: doc/BRIEF.md
# Serial-Port Successive-Approximation Conversion Sequencer

This block is the digital core on the device side of an 8-bit successive-approximation converter that a host drives over a serial link. The host pulls the select line `cs_n` low and then clocks a request in on `di`. The request is a start bit followed by a two-bit input-configuration word. The block turns that word into analog multiplexer controls. It then runs the binary search in lockstep with the serial clock, one result bit per clock. On each trial it presents a code to the ladder and reads back one comparator bit. The result goes back on `do_out` twice: first most-significant-bit first, each bit being the live comparator decision, and then least-significant-bit first, replayed from the shift register that held the decisions. The output enable `do_oe` lets the pad go high-impedance, so `di` and `do_out` can share one wire.

The control is a single state machine with these states:
- `ST_IDLE` waits for a start bit.
- `ST_ADDR` shifts in the configuration word.
- `ST_SETTLE` is one quiet clock for the multiplexer.
- `ST_MSB` runs the eight search steps.
- `ST_LSB` replays seven stored bits.
- `ST_TAIL` holds a low output.

The transitions are:
- IDLE→ADDR on `di`=1 at a rising edge.
- ADDR→SETTLE after the last configuration bit.
- SETTLE→MSB after one clock.
- MSB→LSB after the eighth decision.
- LSB→TAIL after the seventh replayed bit.
- TAIL stays in TAIL.
- Any state returns to IDLE, with every register cleared, as soon as `cs_n` goes high.

Top module: `sar_serial_core`

## Requirements
- R1: While `cs_n` is high, every register is held cleared: `do_oe`=0, `trial_code`=0 and the state is IDLE. Raising `cs_n` in the middle of a conversion aborts it at once, and the next transaction is unaffected.
- R2: After `cs_n` falls, `di`=0 at rising edges keeps the block waiting. The first `di`=1 sampled on a rising edge is the start bit. `do_oe` stays 0 through the start bit and the configuration bits.
- R3: The two `di` bits that follow the start bit are captured in order. The first drives `mux_single`: 1 means single-ended, 0 means differential. The second drives `mux_odd`. The resulting inputs are: single with odd=0 is channel 0 against ground; single with odd=1 is channel 1 against ground; differential with odd=0 is channel 0 positive and channel 1 negative; differential with odd=1 is channel 1 positive and channel 0 negative.
- R4: Once the configuration is captured, `di` is ignored until `cs_n` goes high. `mux_single` and `mux_odd` hold, and the result does not change.
- R5: The clock after the configuration is a settling clock, with `do_oe`=1 and `do_out`=0.
- R6: There are eight search steps k=0..7. At step k, `trial_code` holds the result bits already decided in bits 7..8-k, a 1 in bit 7-k and zeros below. `do_out` equals `cmp_in` during the step, and a 1 keeps bit 7-k. Outside the settling clock and the search steps, `trial_code` is 0; in the settling clock it is 0x80.
- R7: After the eighth step, seven clocks put result bits 1, 2, …, 7 on `do_out`, in that order.
- R8: After the replay, `do_out`=0 with `do_oe`=1 until `cs_n` goes high. Once enabled, `do_oe` never drops while `cs_n` stays low.
- R9: When the positive input is below the negative input, the comparator rejects every trial and the result is 0000 0000 on both streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state moves on its rising edge |
| cs_n | input | 1 | Select, active low; high clears all state asynchronously |
| di | input | 1 | Serial request input (start bit, then configuration word) |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above `trial_code` |
| trial_code | output | 8 | Code presented to the ladder for the current trial |
| mux_single | output | 1 | 1 = single-ended input, 0 = differential |
| mux_odd | output | 1 | Selects channel 1 as the positive input when 1 |
| do_out | output | 1 | Serial result data |
| do_oe | output | 1 | Output enable for the serial data pad |

## Verification
In every search step, the comparator decision is both driven out on `do_out` and shifted into the register that later feeds the replay. On the same clocks `di` is still toggling. The bench therefore drives `di` with alternating ones and zeros, each of which looks like a fresh start bit, throughout the search and the replay. It then judges every most-significant-first bit, every replayed bit and the multiplexer outputs against a result computed arithmetically from the channel values. A select abort is also made to land on a search step, and the clear that follows is checked in the same cycle and again on the next transaction.

// File: rtl/sar_pkg.sv
package sar_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETTLE,
        ST_MSB,
        ST_LSB,
        ST_TAIL
    } sar_state_e;

endpackage

// File: rtl/sar_ctrl.sv
module sar_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W  = 8,
    parameter int ADDR_W = 2,
    parameter int CNT_W  = 3
) (
    input  logic             clk,
    input  logic             cs_n,
    input  logic             di,
    output sar_state_e       state_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] MSB_LAST  = CNT_W'(RES_W - 1);
    localparam logic [CNT_W-1:0] LSB_LAST  = CNT_W'(RES_W - 2);

    sar_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;

    // state register, cleared asynchronously by deselect
    always_ff @(posedge clk or posedge cs_n) begin
        if (cs_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (di) begin
                    state_nxt = ST_ADDR;
                    cnt_nxt   = '0;
                end
            end
            ST_ADDR: begin
                if (cnt == ADDR_LAST) begin
                    state_nxt = ST_SETTLE;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_SETTLE: begin
                state_nxt = ST_MSB;
                cnt_nxt   = '0;
            end
            ST_MSB: begin
                if (cnt == MSB_LAST) begin
                    state_nxt = ST_LSB;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_LSB: begin
                if (cnt == LSB_LAST) begin
                    state_nxt = ST_TAIL;
                    cnt_nxt   = '0;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_TAIL: begin
                state_nxt = ST_TAIL;
                cnt_nxt   = '0;
            end
            default: begin
                state_nxt = ST_IDLE;
                cnt_nxt   = '0;
            end
        endcase
    end

    assign state_o = state;
    assign cnt_o   = cnt;

    // R2: without a start bit the machine keeps waiting
    assert_wait_for_start_R2: assert property (@(posedge clk) disable iff (cs_n)
        (state == ST_IDLE && !di) |=> (state == ST_IDLE));

    // R8: the tail state is never left while selected
    assert_tail_holds_R8: assert property (@(posedge clk) disable iff (cs_n)
        (state == ST_TAIL) |=> (state == ST_TAIL));

endmodule

// File: rtl/sar_addr_capture.sv
module sar_addr_capture #(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              cs_n,
    input  logic              shift_en,
    input  logic              di,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or posedge cs_n) begin
        if (cs_n) begin
            addr_q <= '0;
        end else if (shift_en) begin
            addr_q <= (addr_q << 1) | ADDR_W'(di);
        end
    end

    assign addr_o = addr_q;

    // R4: outside the address window the configuration word cannot move
    assert_addr_frozen_R4: assert property (@(posedge clk) disable iff (cs_n)
        !shift_en |=> $stable(addr_q));

endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int RES_W = 8,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             cs_n,
    input  logic             decide_en,
    input  logic             replay_en,
    input  logic             trial_en,
    input  logic [CNT_W-1:0] step,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial_o,
    output logic             replay_bit_o
);

    localparam logic [CNT_W-1:0] TOP_SHIFT = CNT_W'(RES_W - 1);

    // decisions enter at bit 0; replay shifts them back out toward bit 0
    logic [RES_W-1:0] dec_q;
    logic [RES_W:0]   trial_ext;
    logic [CNT_W-1:0] shamt;

    always_ff @(posedge clk or posedge cs_n) begin
        if (cs_n) begin
            dec_q <= '0;
        end else if (decide_en) begin
            dec_q <= {dec_q[RES_W-2:0], cmp_in};
        end else if (replay_en) begin
            dec_q <= dec_q >> 1;
        end
    end

    // decided bits on top, the trial bit below them, zeros under it
    always_comb begin
        shamt     = TOP_SHIFT - step;
        trial_ext = {dec_q, 1'b1} << shamt;
        trial_o   = trial_en ? trial_ext[RES_W-1:0] : '0;
    end

    assign replay_bit_o = dec_q[1];

    // R6: the first decision becomes the top bit of the next trial
    assert_first_decision_kept_R6: assert property (@(posedge clk) disable iff (cs_n)
        (decide_en && step == '0) |=> (!trial_en || trial_o[RES_W-1] == $past(cmp_in)));

endmodule

// File: rtl/sar_serial_core.sv
module sar_serial_core
    import sar_pkg::*;
#(
    parameter int RES_W  = 8,
    parameter int ADDR_W = 2
) (
    input  logic             clk,
    input  logic             cs_n,
    input  logic             di,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial_code,
    output logic             mux_single,
    output logic             mux_odd,
    output logic             do_out,
    output logic             do_oe
);

    localparam int CNT_W = $clog2((RES_W > ADDR_W) ? RES_W : ADDR_W);

    sar_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr;
    logic              replay_bit;

    sar_ctrl #(
        .RES_W (RES_W),
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk    (clk),
        .cs_n   (cs_n),
        .di     (di),
        .state_o(state),
        .cnt_o  (cnt)
    );

    sar_addr_capture #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk     (clk),
        .cs_n    (cs_n),
        .shift_en(state == ST_ADDR),
        .di      (di),
        .addr_o  (addr)
    );

    sar_search #(
        .RES_W(RES_W),
        .CNT_W(CNT_W)
    ) u_search (
        .clk         (clk),
        .cs_n        (cs_n),
        .decide_en   (state == ST_MSB),
        .replay_en   (state == ST_LSB),
        .trial_en    (state == ST_SETTLE || state == ST_MSB),
        .step        (cnt),
        .cmp_in      (cmp_in),
        .trial_o     (trial_code),
        .replay_bit_o(replay_bit)
    );

    // first captured bit selects single-ended, the last one the odd channel
    assign mux_single = addr[ADDR_W-1];
    assign mux_odd    = addr[0];

    // output process
    always_comb begin
        do_oe  = 1'b0;
        do_out = 1'b0;
        unique case (state)
            ST_IDLE, ST_ADDR: begin
                do_oe  = 1'b0;
                do_out = 1'b0;
            end
            ST_SETTLE: begin
                do_oe  = 1'b1;
                do_out = 1'b0;
            end
            ST_MSB: begin
                do_oe  = 1'b1;
                do_out = cmp_in;
            end
            ST_LSB: begin
                do_oe  = 1'b1;
                do_out = replay_bit;
            end
            ST_TAIL: begin
                do_oe  = 1'b1;
                do_out = 1'b0;
            end
            default: begin
                do_oe  = 1'b0;
                do_out = 1'b0;
            end
        endcase
    end

    // R1: deselect keeps the pad released and the ladder code cleared
    assert_deselect_clear_R1: assert property (@(posedge clk)
        cs_n |-> (!do_oe && trial_code == '0));

    // R5: the pad turns on driving low
    assert_settle_low_R5: assert property (@(posedge clk) disable iff (cs_n)
        $rose(do_oe) |-> !do_out);

    // R7: the first replayed bit is the decision made two steps earlier
    assert_replay_bit1_R7: assert property (@(posedge clk) disable iff (cs_n)
        (state == ST_LSB && cnt == '0) |-> (do_out == $past(cmp_in, 2)));

    // R8: once enabled, the pad stays enabled until deselect
    assert_oe_sticky_R8: assert property (@(posedge clk) disable iff (cs_n)
        $past(do_oe) |-> do_oe);

endmodule

// File: tb/sar_serial_core_tb.sv
module sar_serial_core_tb;

    logic       clk = 1'b0;
    logic       cs_n = 1'b1;
    logic       di = 1'b0;
    logic       cmp_in;
    logic [7:0] trial_code;
    logic       mux_single, mux_odd, do_out, do_oe;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;
    int a0 = 0;
    int a1 = 0;

    always #2.5 clk = ~clk;

    sar_serial_core u_dut (
        .clk       (clk),
        .cs_n      (cs_n),
        .di        (di),
        .cmp_in    (cmp_in),
        .trial_code(trial_code),
        .mux_single(mux_single),
        .mux_odd   (mux_odd),
        .do_out    (do_out),
        .do_oe     (do_oe)
    );

    // analog model: multiplexer, ladder and comparator
    always_comb begin
        int vp, vn, d;
        vp = mux_odd ? a1 : a0;
        vn = mux_single ? 0 : (mux_odd ? a0 : a1);
        d  = (vp > vn) ? vp - vn : 0;
        cmp_in = (d >= int'(trial_code));
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one full transaction; abort_at >= 0 raises cs_n during that search step
    task automatic xfer(input bit sgl, input bit odd, input int v0, input int v1,
                        input int lead, input int noise, input int abort_at);
        int exp, vp, vn, tr;
        bit nb;
        a0 = v0;
        a1 = v1;
        vp = odd ? v1 : v0;
        vn = sgl ? 0 : (odd ? v0 : v1);
        exp = (vp > vn) ? vp - vn : 0;
        nb = 1'b0;
        @(negedge clk);
        cs_n = 1'b0;
        di = 1'b0;
        for (int i = 0; i < lead; i++) begin
            @(negedge clk);
            check(do_oe == 1'b0, "R2 idle oe", int'(do_oe), 0);
        end
        di = 1'b1;
        @(negedge clk);
        check(do_oe == 1'b0, "R2 oe during address", int'(do_oe), 0);
        di = sgl;
        @(negedge clk);
        check(do_oe == 1'b0, "R2 oe during address", int'(do_oe), 0);
        di = odd;
        @(negedge clk);
        check(do_oe == 1'b1 && do_out == 1'b0, "R5 settle", {30'd0, do_oe, do_out}, 2);
        check(mux_single == sgl, "R3 single flag", int'(mux_single), int'(sgl));
        check(mux_odd == odd, "R3 odd flag", int'(mux_odd), int'(odd));
        check(trial_code == 8'h80, "R6 settle trial", int'(trial_code), 128);
        for (int k = 0; k < 8; k++) begin
            nb = (noise == 0) ? 1'b0 : ((noise == 1) ? ~nb : 1'b1);
            di = nb;
            @(negedge clk);
            tr = ((exp >> (8 - k)) << (8 - k)) | (128 >> k);
            check(int'(trial_code) == tr, "R6 trial code", int'(trial_code), tr);
            check(do_out == exp[7-k], "R6 MSB-first bit", int'(do_out), exp[7-k]);
            if (exp == 0)
                check(do_out == 1'b0, "R9 zero result", int'(do_out), 0);
            if (k == abort_at) begin
                cs_n = 1'b1;
                #1;
                check(do_oe == 1'b0 && trial_code == 8'd0, "R1 abort clear",
                      int'(trial_code) + (do_oe ? 256 : 0), 0);
                return;
            end
        end
        for (int j = 1; j < 8; j++) begin
            nb = (noise == 0) ? 1'b0 : ((noise == 1) ? ~nb : 1'b1);
            di = nb;
            @(negedge clk);
            check(do_out == exp[j], "R7 LSB-first bit", int'(do_out), exp[j]);
            check(trial_code == 8'd0, "R6 trial cleared after search", int'(trial_code), 0);
        end
        for (int t = 0; t < 3; t++) begin
            di = ~di;
            @(negedge clk);
            check(do_oe == 1'b1 && do_out == 1'b0, "R8 tail", {30'd0, do_oe, do_out}, 2);
            check(mux_single == sgl && mux_odd == odd, "R4 mux held",
                  {30'd0, mux_single, mux_odd}, {30'd0, sgl, odd});
        end
        cs_n = 1'b1;
        di = 1'b0;
        #1;
        check(do_oe == 1'b0, "R1 release on deselect", int'(do_oe), 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(do_oe == 1'b0, "R1 reset oe", int'(do_oe), 0);
        check(trial_code == 8'd0, "R1 reset trial", int'(trial_code), 0);
        check(mux_single == 1'b0 && mux_odd == 1'b0, "R1 reset mux",
              {30'd0, mux_single, mux_odd}, 0);
        // single-ended sweeps on both channels
        for (int v = 0; v < 256; v++) xfer(1'b1, 1'b0, v, 255 - v, v % 3, v % 3, -1);
        for (int v = 0; v < 256; v++) xfer(1'b1, 1'b1, 255 - v, v, 1, 2, -1);
        // differential, both polarities, including negative differences (R9)
        for (int v = 0; v < 256; v++) xfer(1'b0, 1'b0, v, (v * 37) % 256, 0, 1, -1);
        for (int v = 0; v < 256; v++) xfer(1'b0, 1'b1, (v * 91 + 17) % 256, v, 2, 2, -1);
        // R9: the negative input well above the positive one
        xfer(1'b0, 1'b0, 10, 200, 0, 2, -1);
        xfer(1'b0, 1'b1, 255, 0, 0, 1, -1);
        // R1: aborts on different search steps, each followed by a clean transaction
        xfer(1'b1, 1'b0, 200, 0, 0, 1, 0);
        xfer(1'b1, 1'b0, 77, 0, 0, 0, -1);
        xfer(1'b0, 1'b1, 3, 250, 1, 2, 5);
        xfer(1'b0, 1'b1, 3, 250, 1, 2, -1);
        xfer(1'b1, 1'b1, 0, 129, 0, 1, 7);
        xfer(1'b1, 1'b1, 0, 129, 0, 1, -1);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule